// File: doc/BRIEF.md
# JTAG Debug Command Decoder

This block is the command front end of a debug unit reached through a user data register of a JTAG TAP. All of its logic runs on TCK. While its select input is high it shifts command bits in from TDI during Shift-DR, least significant bit first, and counts them. On Update-DR it decodes the word it has gathered. A command has a variable length, and the last bit shifted is its top bit. When the top bit is 1, the word selects one module of the unit. When it is 0, the word is a command for the module already selected: an internal register select, an internal register write, or a burst setup.

A burst setup carries an opcode, a start address and a word count. It goes out to a burst engine through a valid/ready channel. The setup is held unchanged until the engine takes it. While one setup is waiting, any further burst command is dropped. The block also holds the unit's error register, which stores a bus-error flag and the address that faulted. During Capture-DR it loads the register chosen by the current module and index into an output shifter, and shifts that shifter out on TDO, LSB first. Shifting in a NOP therefore reads the chosen register.

Top module: `dbg_cmd_decoder`

## Requirements
- R1: After reset no module is selected, no burst setup is pending, every register index is 0, and the error register reads as all zeros.
- R2: A 3-bit command whose top bit is 1 selects the module given by its two lower bits (0, 1 or 2). The value 3, or any other length with the top bit set, is ignored. Once a module is selected, some module stays selected.
- R3: State changes only on an Update-DR cycle while the select input is high. Bits shifted, captured or updated while select is low have no effect.
- R4: A 53-bit command with top bit 0 and a burst opcode raises burst_valid. From the top bit down, the fields are flag, 4-bit opcode, 32-bit address and 16-bit count. The setup holds steady until burst_valid and burst_ready are both high. A burst command that arrives while a setup is waiting is dropped.
- R5: Burst opcodes are 1, 2, 3 (write of 8, 16 or 32 bits) and 5, 6, 7 (read of 8, 16 or 32 bits). burst_write is 1 for the writes. burst_size is 0, 1 or 2 for 8, 16 or 32 bits. burst_module is the selected module.
- R6: A module-level command is ignored while no module is selected.
- R7: Opcode 13 with exactly 7 bits (flag, opcode, 2-bit index) selects an internal register. Opcode 9 with 8 to 40 bits is an internal register write, with the data below the index. The data's first shifted bit is data bit 0. Any other opcode, or a wrong length, changes nothing.
- R8: Capture-DR loads the output shifter, and TDO presents it LSB first. In module 0 at index 0 the value is the error register: bit 0 is the flag and bits 32:1 are the faulting address. Every other module and index reads 0.
- R9: A bus_err pulse while the flag is clear sets the flag and latches bus_err_addr. Later pulses leave both unchanged while the flag is set.
- R10: A register write to module 0 at index 0 with data bit 0 equal to 1 clears the flag and keeps the address. Data bit 0 equal to 0 has no effect. A bus_err in the same cycle as a clear sets the flag and latches the new address.
- R11: Each module keeps its own register index. A register select or a register write updates only the index of the selected module. sel_index shows the index of the selected module.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | TAP clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | This unit's data register is selected in the TAP |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial command input |
| tdo | output | 1 | Serial read-back output |
| bus_err | input | 1 | Bus-error pulse from the bus master |
| bus_err_addr | input | 32 | Address of the faulting access |
| sel_valid | output | 1 | A module is selected |
| sel_module | output | 2 | Selected module number |
| sel_index | output | 2 | Register index of the selected module |
| burst_valid | output | 1 | A burst setup is offered |
| burst_ready | input | 1 | The burst engine accepts the setup |
| burst_module | output | 2 | Module that owns the burst |
| burst_write | output | 1 | 1 for a write burst, 0 for a read burst |
| burst_size | output | 2 | Word size: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits |
| burst_addr | output | 32 | Burst start address |
| burst_len | output | 16 | Burst word count |

## Verification
Decoded results come out of one register stage. Module and index selection, burst_valid with its fields, and error-register clears all show after the clock edge that samples Update-DR. The bench drives on falling edges and checks one falling edge after the update cycle. A read-back bit appears on TDO one edge after Capture-DR, and each later bit one edge after a shift. The bench therefore samples TDO at each falling edge before it drives the next shift. Burst setups go into a scoreboard queue when they are sent. A monitor compares them at the rising edge where valid and ready are both high, using the values held before that edge. Any offer the queue did not predict counts as a failure.

// File: rtl/dbgcmd_pkg.sv
package dbgcmd_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OPC_NOP  = 4'd0;
  localparam logic [OP_W-1:0] OPC_BW8  = 4'd1;
  localparam logic [OP_W-1:0] OPC_BW16 = 4'd2;
  localparam logic [OP_W-1:0] OPC_BW32 = 4'd3;
  localparam logic [OP_W-1:0] OPC_BR8  = 4'd5;
  localparam logic [OP_W-1:0] OPC_BR16 = 4'd6;
  localparam logic [OP_W-1:0] OPC_BR32 = 4'd7;
  localparam logic [OP_W-1:0] OPC_RWR  = 4'd9;
  localparam logic [OP_W-1:0] OPC_RSEL = 4'd13;

  typedef enum logic [2:0] {
    CK_NONE,
    CK_MODSEL,
    CK_REGSEL,
    CK_REGWR,
    CK_BURST
  } cmd_kind_e;

endpackage

// File: rtl/dbgcmd_shifter.sv
module dbgcmd_shifter #(
  parameter int SR_W  = 53,
  parameter int CNT_W = 6,
  parameter int RD_W  = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             capture,
  input  logic             shift,
  input  logic             tdi,
  input  logic [RD_W-1:0]  rd_val,
  output logic [SR_W-1:0]  sr,
  output logic [CNT_W-1:0] cnt,
  output logic             tdo
);

  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(SR_W + 1);

  logic [RD_W-1:0] out_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      cnt    <= '0;
      out_sr <= '0;
    end else if (sel && capture) begin
      cnt    <= '0;
      out_sr <= rd_val;
    end else if (sel && shift) begin
      sr     <= {tdi, sr[SR_W-1:1]};
      out_sr <= {1'b0, out_sr[RD_W-1:1]};
      if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
    end
  end

  assign tdo = out_sr[0];

endmodule

// File: rtl/dbgcmd_decode.sv
module dbgcmd_decode
  import dbgcmd_pkg::*;
#(
  parameter int SR_W    = 53,
  parameter int CNT_W   = 6,
  parameter int MOD_W   = 2,
  parameter int NUM_MOD = 3,
  parameter int IDX_W   = 2,
  parameter int DATA_W  = 33,
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16
) (
  input  logic [SR_W-1:0]   sr,
  input  logic [CNT_W-1:0]  cnt,
  output cmd_kind_e         kind,
  output logic [MOD_W-1:0]  mod,
  output logic [OP_W-1:0]   op,
  output logic [IDX_W-1:0]  idx,
  output logic              wbit0,
  output logic [ADDR_W-1:0] addr,
  output logic [LEN_W-1:0]  len
);

  localparam int HDR_W   = 1 + OP_W + IDX_W;
  localparam int BURST_W = 1 + OP_W + ADDR_W + LEN_W;
  localparam int PTR_W   = $clog2(SR_W);

  int c;

  // fields sit just below the top bit, which is the last one shifted
  assign mod  = sr[SR_W-2 -: MOD_W];
  assign op   = sr[SR_W-2 -: OP_W];
  assign idx  = sr[SR_W-2-OP_W -: IDX_W];
  assign addr = sr[SR_W-2-OP_W -: ADDR_W];
  assign len  = sr[SR_W-2-OP_W-ADDR_W -: LEN_W];

  always_comb begin
    c     = int'(cnt);
    kind  = CK_NONE;
    wbit0 = 1'b0;
    if (c > 0 && c <= SR_W) wbit0 = sr[PTR_W'(SR_W - c)];
    if (sr[SR_W-1]) begin
      if (c == 1 + MOD_W && int'(mod) < NUM_MOD) kind = CK_MODSEL;
    end else begin
      case (op)
        OPC_RSEL: if (c == HDR_W) kind = CK_REGSEL;
        OPC_RWR:  if (c > HDR_W && c <= HDR_W + DATA_W) kind = CK_REGWR;
        OPC_BW8, OPC_BW16, OPC_BW32,
        OPC_BR8, OPC_BR16, OPC_BR32:
                  if (c == BURST_W) kind = CK_BURST;
        default:  kind = CK_NONE;
      endcase
    end
  end

endmodule

// File: rtl/dbgcmd_errreg.sv
module dbgcmd_errreg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_err,
  input  logic [ADDR_W-1:0] bus_err_addr,
  input  logic              clr,
  output logic              flag,
  output logic [ADDR_W-1:0] addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      addr <= '0;
    end else if (bus_err && (!flag || clr)) begin
      flag <= 1'b1;
      addr <= bus_err_addr;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

endmodule

// File: rtl/dbg_cmd_decoder.sv
module dbg_cmd_decoder
  import dbgcmd_pkg::*;
#(
  parameter int NUM_MOD = 3,
  parameter int MOD_W   = 2,
  parameter int IDX_W   = 2,
  parameter int DATA_W  = 33,
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int ERR_MOD = 0,
  parameter int ERR_IDX = 0
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo,
  input  logic              bus_err,
  input  logic [ADDR_W-1:0] bus_err_addr,
  output logic              sel_valid,
  output logic [MOD_W-1:0]  sel_module,
  output logic [IDX_W-1:0]  sel_index,
  output logic              burst_valid,
  input  logic              burst_ready,
  output logic [MOD_W-1:0]  burst_module,
  output logic              burst_write,
  output logic [1:0]        burst_size,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [LEN_W-1:0]  burst_len
);

  localparam int BURST_W = 1 + OP_W + ADDR_W + LEN_W;
  localparam int WR_W    = 1 + OP_W + IDX_W + DATA_W;
  localparam int SR_W    = (BURST_W > WR_W) ? BURST_W : WR_W;
  localparam int CNT_W   = $clog2(SR_W + 2);
  localparam int ERR_W   = 1 + ADDR_W;
  localparam logic [MOD_W-1:0] ERR_M = MOD_W'(ERR_MOD);
  localparam logic [IDX_W-1:0] ERR_I = IDX_W'(ERR_IDX);

  logic [SR_W-1:0]  sr;
  logic [CNT_W-1:0] cnt;
  logic [ERR_W-1:0] rd_val;
  cmd_kind_e        kind;
  logic [MOD_W-1:0] dec_mod;
  logic [OP_W-1:0]  dec_op;
  logic [IDX_W-1:0] dec_idx;
  logic             dec_wbit0;
  logic [ADDR_W-1:0] dec_addr;
  logic [LEN_W-1:0] dec_len;
  logic             err_flag;
  logic [ADDR_W-1:0] err_addr;
  logic             err_clr;
  logic             upd;
  logic             mod_cmd;
  logic             burst_take;
  logic [NUM_MOD-1:0][IDX_W-1:0] idx_q;

  dbgcmd_shifter #(.SR_W(SR_W), .CNT_W(CNT_W), .RD_W(ERR_W)) i_shifter (
    .clk(tck), .rst_n(rst_n), .sel(sel), .capture(capture_dr),
    .shift(shift_dr), .tdi(tdi), .rd_val(rd_val), .sr(sr), .cnt(cnt),
    .tdo(tdo)
  );

  dbgcmd_decode #(
    .SR_W(SR_W), .CNT_W(CNT_W), .MOD_W(MOD_W), .NUM_MOD(NUM_MOD),
    .IDX_W(IDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) i_decode (
    .sr(sr), .cnt(cnt), .kind(kind), .mod(dec_mod), .op(dec_op),
    .idx(dec_idx), .wbit0(dec_wbit0), .addr(dec_addr), .len(dec_len)
  );

  dbgcmd_errreg #(.ADDR_W(ADDR_W)) i_errreg (
    .clk(tck), .rst_n(rst_n), .bus_err(bus_err), .bus_err_addr(bus_err_addr),
    .clr(err_clr), .flag(err_flag), .addr(err_addr)
  );

  assign upd        = update_dr && sel;
  assign mod_cmd    = upd && sel_valid;
  assign err_clr    = mod_cmd && kind == CK_REGWR && sel_module == ERR_M &&
                      dec_idx == ERR_I && dec_wbit0;
  assign burst_take = mod_cmd && kind == CK_BURST && (!burst_valid || burst_ready);

  // unit-level module selection
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sel_valid  <= 1'b0;
      sel_module <= '0;
    end else if (upd && kind == CK_MODSEL) begin
      sel_valid  <= 1'b1;
      sel_module <= dec_mod;
    end
  end

  // one register index per module
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (mod_cmd && (kind == CK_REGSEL || kind == CK_REGWR)) begin
      for (int m = 0; m < NUM_MOD; m++)
        if (sel_module == MOD_W'(m)) idx_q[m] <= dec_idx;
    end
  end

  always_comb begin
    sel_index = '0;
    for (int m = 0; m < NUM_MOD; m++)
      if (sel_module == MOD_W'(m)) sel_index = idx_q[m];
  end

  assign rd_val = (sel_valid && sel_module == ERR_M && idx_q[ERR_MOD] == ERR_I) ?
                  {err_addr, err_flag} : '0;

  // burst setup holding stage
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      burst_valid  <= 1'b0;
      burst_module <= '0;
      burst_write  <= 1'b0;
      burst_size   <= '0;
      burst_addr   <= '0;
      burst_len    <= '0;
    end else if (burst_take) begin
      burst_valid  <= 1'b1;
      burst_module <= sel_module;
      burst_write  <= ~dec_op[2];
      burst_size   <= dec_op[1:0] - 2'd1;
      burst_addr   <= dec_addr;
      burst_len    <= dec_len;
    end else if (burst_ready) begin
      burst_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/dbgcmd_chk.sv
module dbgcmd_chk #(
  parameter int MOD_W  = 2,
  parameter int IDX_W  = 2,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              update_dr,
  input logic              sel_valid,
  input logic [MOD_W-1:0]  sel_module,
  input logic [IDX_W-1:0]  sel_index,
  input logic              burst_valid,
  input logic              burst_ready,
  input logic [ADDR_W-1:0] burst_addr,
  input logic [LEN_W-1:0]  burst_len,
  input logic              err_flag,
  input logic [ADDR_W-1:0] err_addr,
  input logic              err_clr
);

  // R2
  sel_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |=> sel_valid);

  // R3
  no_update_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(update_dr && sel) |=> $stable(sel_valid) && $stable(sel_module) && $stable(sel_index));

  // R4
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && !burst_ready |=> burst_valid && $stable(burst_addr) && $stable(burst_len));

  // R4
  burst_from_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_valid) |-> $past(update_dr && sel));

  // R9
  err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag && $stable(err_addr));

endmodule

bind dbg_cmd_decoder dbgcmd_chk #(
  .MOD_W(MOD_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) i_chk (
  .clk(tck), .rst_n(rst_n), .sel(sel), .update_dr(update_dr),
  .sel_valid(sel_valid), .sel_module(sel_module), .sel_index(sel_index),
  .burst_valid(burst_valid), .burst_ready(burst_ready),
  .burst_addr(burst_addr), .burst_len(burst_len),
  .err_flag(err_flag), .err_addr(err_addr), .err_clr(err_clr)
);

// File: tb/test_dbg_cmd_decoder.sv
`timescale 1ns/1ps
module test_dbg_cmd_decoder;

  logic        tck = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b1;
  logic        capture_dr = 1'b0;
  logic        shift_dr = 1'b0;
  logic        update_dr = 1'b0;
  logic        tdi = 1'b0;
  logic        tdo;
  logic        bus_err = 1'b0;
  logic [31:0] bus_err_addr = '0;
  logic        sel_valid;
  logic [1:0]  sel_module;
  logic [1:0]  sel_index;
  logic        burst_valid;
  logic        burst_ready = 1'b1;
  logic [1:0]  burst_module;
  logic        burst_write;
  logic [1:0]  burst_size;
  logic [31:0] burst_addr;
  logic [15:0] burst_len;

  int checks = 0;
  int fails = 0;
  logic [52:0] exp_q[$];

  always #2 tck = ~tck;

  dbg_cmd_decoder i_dbg_cmd_decoder (
    .tck(tck), .rst_n(rst_n), .sel(sel), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
    .bus_err(bus_err), .bus_err_addr(bus_err_addr),
    .sel_valid(sel_valid), .sel_module(sel_module), .sel_index(sel_index),
    .burst_valid(burst_valid), .burst_ready(burst_ready),
    .burst_module(burst_module), .burst_write(burst_write),
    .burst_size(burst_size), .burst_addr(burst_addr), .burst_len(burst_len)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] v, input int n, input logic s = 1'b1,
                      input logic err_same = 1'b0, input logic [31:0] ea = '0);
    @(negedge tck); sel = s; capture_dr = 1'b1;
    @(negedge tck); capture_dr = 1'b0;
    for (int i = 0; i < n; i++) begin
      shift_dr = 1'b1; tdi = v[i];
      @(negedge tck);
    end
    shift_dr = 1'b0; update_dr = 1'b1;
    if (err_same) begin bus_err = 1'b1; bus_err_addr = ea; end
    @(negedge tck);
    update_dr = 1'b0; bus_err = 1'b0; sel = 1'b1;
  endtask

  task automatic read_back(input int n, output logic [63:0] r);
    r = '0;
    @(negedge tck); capture_dr = 1'b1;
    @(negedge tck); capture_dr = 1'b0;
    for (int i = 0; i < n; i++) begin
      r[i] = tdo; shift_dr = 1'b1;
      @(negedge tck);
    end
    shift_dr = 1'b0;
  endtask

  task automatic modsel(input logic [1:0] m);
    send(64'(4 | m), 3);
  endtask

  task automatic regsel(input logic [1:0] ix);
    send(64'((13 << 2) | ix), 7);
  endtask

  task automatic regwr(input logic [1:0] ix, input logic [63:0] d, input int nd,
                       input logic err_same = 1'b0, input logic [31:0] ea = '0);
    send((64'((9 << 2) | ix) << nd) | d, 7 + nd, 1'b1, err_same, ea);
  endtask

  task automatic burst(input logic [3:0] op, input logic [31:0] a, input logic [15:0] l);
    send({11'b0, 1'b0, op, a, l}, 53);
  endtask

  task automatic pulse_err(input logic [31:0] a);
    @(negedge tck); bus_err = 1'b1; bus_err_addr = a;
    @(negedge tck); bus_err = 1'b0;
  endtask

  // scoreboard monitor: compares at the accepting edge, pre-edge values
  always @(posedge tck) begin
    if (rst_n && burst_valid && burst_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R4/R6: unexpected burst actual 0x%0h expected none",
                 {burst_module, burst_write, burst_size, burst_addr, burst_len});
      end else begin
        logic [52:0] e;
        e = exp_q.pop_front();
        if ({burst_module, burst_write, burst_size, burst_addr, burst_len} !== e) begin
          fails++;
          $display("FAIL R5: burst actual 0x%0h expected 0x%0h",
                   {burst_module, burst_write, burst_size, burst_addr, burst_len}, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] r;
    repeat (3) @(negedge tck);
    rst_n = 1'b1;
    @(negedge tck);
    // R1 reset state
    chk(sel_valid == 1'b0, "R1 sel_valid", 64'(sel_valid), 0);
    chk(burst_valid == 1'b0, "R1 burst_valid", 64'(burst_valid), 0);

    // R6 module command with no module selected
    burst(4'd3, 32'h1111_0000, 16'd4);
    chk(burst_valid == 1'b0, "R6 burst without module", 64'(burst_valid), 0);

    // R2 illegal selects
    modsel(2'd3);
    chk(sel_valid == 1'b0, "R2 module 3 ignored", 64'(sel_valid), 0);
    send(64'b1010, 4);
    chk(sel_valid == 1'b0, "R2 wrong length ignored", 64'(sel_valid), 0);
    modsel(2'd0);
    chk({sel_valid, sel_module} == 3'b100, "R2 select module 0",
        64'({sel_valid, sel_module}), 64'b100);
    chk(sel_index == 2'd0, "R1 index zero", 64'(sel_index), 0);
    read_back(33, r);
    chk(r == 0, "R1 error register zero", r, 0);

    // R3 select low
    send(64'(4 | 2), 3, 1'b0);
    chk(sel_module == 2'd0, "R3 sel low ignored", 64'(sel_module), 0);

    // R9 / R8 error latch and read-back
    pulse_err(32'h1234_5678);
    read_back(33, r);
    chk(r == {31'b0, 32'h1234_5678, 1'b1}, "R8 R9 error read", r, {31'b0, 32'h1234_5678, 1'b1});
    pulse_err(32'hAAAA_0004);
    read_back(33, r);
    chk(r == {31'b0, 32'h1234_5678, 1'b1}, "R9 first error kept", r, {31'b0, 32'h1234_5678, 1'b1});

    // R10 clear
    regwr(2'd0, 64'd0, 1);
    read_back(33, r);
    chk(r == {31'b0, 32'h1234_5678, 1'b1}, "R10 write 0 no effect", r, {31'b0, 32'h1234_5678, 1'b1});
    regwr(2'd0, 64'd1, 1);
    read_back(33, r);
    chk(r == {31'b0, 32'h1234_5678, 1'b0}, "R10 clear flag", r, {31'b0, 32'h1234_5678, 1'b0});
    pulse_err(32'h0000_0C00);
    regwr(2'd0, 64'd1, 1, 1'b1, 32'h0000_0D00);
    read_back(33, r);
    chk(r == {31'b0, 32'h0000_0D00, 1'b1}, "R10 new error wins", r, {31'b0, 32'h0000_0D00, 1'b1});
    regwr(2'd0, 64'h1_0000_0001, 33);
    read_back(33, r);
    chk(r == {31'b0, 32'h0000_0D00, 1'b0}, "R10 clear with long data", r, {31'b0, 32'h0000_0D00, 1'b0});

    // R11 per-module indices
    regsel(2'd1);
    chk(sel_index == 2'd1, "R11 select index 1", 64'(sel_index), 1);
    read_back(33, r);
    chk(r == 0, "R8 other index reads 0", r, 0);
    modsel(2'd1);
    chk(sel_index == 2'd0, "R11 module 1 own index", 64'(sel_index), 0);
    read_back(33, r);
    chk(r == 0, "R8 module 1 reads 0", r, 0);
    regsel(2'd2);
    modsel(2'd0);
    chk(sel_index == 2'd1, "R11 module 0 kept index", 64'(sel_index), 1);
    regsel(2'd0);
    read_back(33, r);
    chk(r == {31'b0, 32'h0000_0D00, 1'b0}, "R11 back to error reg", r, {31'b0, 32'h0000_0D00, 1'b0});

    // R7 undefined opcode and wrong length
    send(64'((10 << 2) | 3), 7);
    chk(sel_index == 2'd0, "R7 undefined opcode ignored", 64'(sel_index), 0);
    send(64'((13 << 2) | 3) << 1, 8);
    chk(sel_index == 2'd0, "R7 wrong length ignored", 64'(sel_index), 0);
    burst(4'd4, 32'h2222_0000, 16'd2);
    chk(burst_valid == 1'b0, "R7 undefined burst opcode", 64'(burst_valid), 0);

    // R4 R5 bursts with ready high
    exp_q.push_back({2'd0, 1'b1, 2'd0, 32'h8000_0000, 16'd1});
    burst(4'd1, 32'h8000_0000, 16'd1);
    chk(burst_valid == 1'b1, "R4 burst offered", 64'(burst_valid), 1);
    exp_q.push_back({2'd0, 1'b0, 2'd1, 32'h0000_1002, 16'hFFFF});
    burst(4'd6, 32'h0000_1002, 16'hFFFF);
    exp_q.push_back({2'd0, 1'b0, 2'd2, 32'hDEAD_BEEC, 16'h0010});
    burst(4'd7, 32'hDEAD_BEEC, 16'h0010);
    modsel(2'd2);
    exp_q.push_back({2'd2, 1'b1, 2'd1, 32'h0000_4000, 16'd8});
    burst(4'd2, 32'h0000_4000, 16'd8);

    // R4 back-pressure
    @(negedge tck); burst_ready = 1'b0;
    exp_q.push_back({2'd2, 1'b0, 2'd0, 32'h0BAD_F00D, 16'd5});
    burst(4'd5, 32'h0BAD_F00D, 16'd5);
    repeat (5) @(negedge tck);
    chk(burst_valid == 1'b1 && burst_addr == 32'h0BAD_F00D, "R4 held under back-pressure",
        {burst_valid, burst_addr}, {1'b1, 32'h0BAD_F00D});
    burst(4'd3, 32'h5555_5555, 16'd9);
    chk(burst_addr == 32'h0BAD_F00D, "R4 second burst dropped", 64'(burst_addr), 64'h0BAD_F00D);
    burst_ready = 1'b1;
    repeat (3) @(negedge tck);
    chk(burst_valid == 1'b0, "R4 released after ready", 64'(burst_valid), 0);
    chk(exp_q.size() == 0, "R5 scoreboard drained", 64'(exp_q.size()), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule